// File: doc/BRIEF.md
# Guest Interrupt Virtualization Controller

This block sits beside a processor core that is running guest code. It decides what happens to each external interrupt and each non-maskable interrupt (NMI) that arrives during that time. An event is either handed to the guest, or it ends the guest run with a VM-exit strobe and an exit reason. The host sets three controls. One turns every external interrupt into an exit. One turns the first moment the guest can take interrupts into an exit. One redirects guest task-priority accesses to a private shadow register, which has a host-set threshold. The block also tracks two pieces of interruptibility state internally: a one-boundary block after a stack-segment load, and NMI masking while an earlier NMI is being handled.

A small state machine runs the decisions. In ST_RUN it looks at the pending events once per cycle and picks at most one. Picking a delivery moves it to ST_DELIVER, which shows the delivery strobe for one cycle and then returns to ST_RUN. Picking an exit moves it to ST_EXIT, which shows the exit strobe and reason for one cycle, and then to ST_HALTED. From ST_HALTED it returns to ST_RUN only on a resume pulse, which stands for the next VM entry. Request pulses are latched, so an event that cannot be served yet stays pending until it can.

Top module: `gintv_ctrl`

## Requirements
- R1: After reset no strobe is active, the exit reason is 0, both interruptibility blocks are clear and the priority shadow is 0.
- R2: An NMI request is delivered (dlv_strobe=1, dlv_nmi=1) in the cycle after it is sampled when NMIs are not blocked, whatever the guest interrupt-enable flag is.
- R3: Once an NMI is delivered, further NMIs stay pending until iret_done is sampled; the held NMI is then delivered at the next decision.
- R4: With ctl_ext_exit=1, an external request causes an exit with reason 1 (01b), even when guest_if=0 and a stack-segment block is active; such a request is never delivered to the guest.
- R5: With ctl_ext_exit=0, an external request is delivered (dlv_strobe=1, dlv_nmi=0) only while guest_if=1 and no stack-segment block is active; until then it stays pending.
- R6: An insn_retire pulse with ss_load=1 sets a block on external delivery and on window exits; the next insn_retire pulse with ss_load=0 clears it.
- R7: With ctl_win_exit=1, an exit with reason 2 (10b) occurs at the first decision where guest_if=1 and no stack-segment block is active.
- R8: A shadow write changes the shadow only when ctl_prio_shadow=1 and long_mode=1; any other write leaves it unchanged. prio_rd_data shows the shadow under the same condition, else 0.
- R9: An accepted shadow write whose value is below prio_thresh (unsigned) causes an exit with reason 3 (11b); a value equal to or above the threshold causes none.
- R10: Each decision serves one event. The order is NMI delivery, then external exit, then priority exit, then window exit, then external delivery. A delivery cycle is followed by a cycle with no strobe.
- R11: After an exit strobe no strobe appears until vm_resume is sampled. Requests that arrive meanwhile are kept and served afterwards.
- R12: Every strobe lasts exactly one cycle, and a delivered event is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External interrupt request pulse |
| nmi_req | input | 1 | NMI request pulse |
| iret_done | input | 1 | Guest finished an interrupt return; lifts NMI masking |
| insn_retire | input | 1 | Guest instruction boundary pulse |
| ss_load | input | 1 | The retiring instruction loaded the stack segment |
| guest_if | input | 1 | Guest interrupt-enable flag |
| long_mode | input | 1 | Guest is in 64-bit mode |
| vm_resume | input | 1 | Host re-enters the guest after an exit |
| ctl_ext_exit | input | 1 | Host control: external interrupts exit |
| ctl_win_exit | input | 1 | Host control: exit when guest can accept interrupts |
| ctl_prio_shadow | input | 1 | Host control: task-priority accesses use the shadow |
| prio_thresh | input | PRIO_W | Host threshold for the shadow |
| prio_wr_en | input | 1 | Guest task-priority write strobe |
| prio_wr_data | input | PRIO_W | Guest task-priority write value |
| prio_rd_data | output | PRIO_W | Shadow value seen by guest reads |
| dlv_strobe | output | 1 | Event delivered to guest |
| dlv_nmi | output | 1 | Delivered event is an NMI (else external) |
| exit_strobe | output | 1 | VM exit taken |
| exit_reason | output | 2 | 1 external, 2 window, 3 priority threshold, 0 none |

## Verification
If the NMI mask is stuck set, a second NMI never shows up at dlv_strobe after iret_done. If it is stuck clear, a second NMI appears one cycle after its request. Either error is visible within two cycles of the stimulus. A stack-segment block that lingers or vanishes early moves the external delivery or the window exit by exactly one cycle relative to the clearing boundary. A lost pending latch shows as a strobe that is missing after resume, and a wrong arbitration order shows as strobes in the wrong sequence. A shadow that accepts forbidden writes shows up on prio_rd_data as soon as the gating is lifted.

// File: rtl/gintv_pkg.sv
package gintv_pkg;
    localparam int REASON_W = 2;
    localparam int NSRC     = 3;
    localparam int SRC_NMI  = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_PRIO = 2;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE   = 2'd0,
        RSN_EXT    = 2'd1,
        RSN_WINDOW = 2'd2,
        RSN_PRIO   = 2'd3
    } exit_rsn_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DELIVER,
        ST_EXIT,
        ST_HALTED
    } ctl_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_NMI_DLV,
        ACT_EXT_EXIT,
        ACT_PRIO_EXIT,
        ACT_WIN_EXIT,
        ACT_EXT_DLV
    } act_t;
endpackage

// File: rtl/gintv_pend.sv
module gintv_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic serve,
    output logic pending
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (serve)
            held_q <= 1'b0;
        else if (req)
            held_q <= 1'b1;
    end

    // a request sampled at this edge can be served at the same edge
    assign pending = held_q | req;
endmodule

// File: rtl/gintv_intstate.sv
module gintv_intstate (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_retire,
    input  logic ss_load,
    input  logic nmi_taken,
    input  logic iret_done,
    output logic ss_blk,
    output logic nmi_blk
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_blk <= 1'b0;
        end else if (insn_retire) begin
            // a stack-segment load arms the block; the next boundary lifts it
            ss_blk <= ss_load;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_blk <= 1'b0;
        end else if (nmi_taken) begin
            nmi_blk <= 1'b1;
        end else if (iret_done) begin
            nmi_blk <= 1'b0;
        end
    end
endmodule

// File: rtl/gintv_prio_shadow.sv
module gintv_prio_shadow #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PRIO_W-1:0] wr_data,
    input  logic              ctl_shadow,
    input  logic              long_mode,
    input  logic [PRIO_W-1:0] thresh,
    output logic [PRIO_W-1:0] shadow_q,
    output logic [PRIO_W-1:0] rd_data,
    output logic              below_hit
);
    logic path_on;
    logic wr_ok;

    assign path_on = ctl_shadow & long_mode;
    assign wr_ok   = wr_en & path_on;

    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_ok)
            shadow_q <= wr_data;
    end

    always_comb begin
        rd_data   = path_on ? shadow_q : '0;
        below_hit = wr_ok && (wr_data < thresh);
    end
endmodule

// File: rtl/gintv_arb.sv
module gintv_arb
    import gintv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic            nmi_blk,
    input  logic            ss_blk,
    input  logic            guest_if,
    input  logic            ctl_ext_exit,
    input  logic            ctl_win_exit,
    input  logic            vm_resume,
    output logic [NSRC-1:0] serve,
    output logic            nmi_taken,
    output logic            dlv_strobe,
    output logic            dlv_nmi,
    output logic            exit_strobe,
    output logic [REASON_W-1:0] exit_reason
);
    ctl_state_t state_q, state_d;
    act_t       act;
    logic       nmi_q;
    exit_rsn_t  rsn_q;
    logic       ext_open;

    assign ext_open = guest_if & ~ss_blk;

    // fixed-priority pick, only while the guest runs
    always_comb begin
        act = ACT_NONE;
        if (state_q == ST_RUN) begin
            if (pend[SRC_NMI] && !nmi_blk)
                act = ACT_NMI_DLV;
            else if (pend[SRC_EXT] && ctl_ext_exit)
                act = ACT_EXT_EXIT;
            else if (pend[SRC_PRIO])
                act = ACT_PRIO_EXIT;
            else if (ctl_win_exit && ext_open)
                act = ACT_WIN_EXIT;
            else if (pend[SRC_EXT] && ext_open)
                act = ACT_EXT_DLV;
        end
    end

    always_comb begin
        serve           = '0;
        serve[SRC_NMI]  = (act == ACT_NMI_DLV);
        serve[SRC_EXT]  = (act == ACT_EXT_EXIT) || (act == ACT_EXT_DLV);
        serve[SRC_PRIO] = (act == ACT_PRIO_EXIT);
        nmi_taken       = (act == ACT_NMI_DLV);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                unique case (act)
                    ACT_NMI_DLV, ACT_EXT_DLV:                 state_d = ST_DELIVER;
                    ACT_EXT_EXIT, ACT_PRIO_EXIT, ACT_WIN_EXIT: state_d = ST_EXIT;
                    default:                                  state_d = ST_RUN;
                endcase
            end
            ST_DELIVER: state_d = ST_RUN;
            ST_EXIT:    state_d = ST_HALTED;
            ST_HALTED:  state_d = vm_resume ? ST_RUN : ST_HALTED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // capture of what was picked, shown while the strobe state lasts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            rsn_q <= RSN_NONE;
        end else if (state_q == ST_RUN) begin
            nmi_q <= (act == ACT_NMI_DLV);
            unique case (act)
                ACT_EXT_EXIT:  rsn_q <= RSN_EXT;
                ACT_PRIO_EXIT: rsn_q <= RSN_PRIO;
                ACT_WIN_EXIT:  rsn_q <= RSN_WINDOW;
                default:       rsn_q <= RSN_NONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        dlv_strobe  = (state_q == ST_DELIVER);
        dlv_nmi     = (state_q == ST_DELIVER) & nmi_q;
        exit_strobe = (state_q == ST_EXIT);
        exit_reason = (state_q == ST_EXIT) ? rsn_q : RSN_NONE;
    end
endmodule

// File: rtl/gintv_ctrl.sv
module gintv_ctrl
    import gintv_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic              nmi_req,
    input  logic              iret_done,
    input  logic              insn_retire,
    input  logic              ss_load,
    input  logic              guest_if,
    input  logic              long_mode,
    input  logic              vm_resume,
    input  logic              ctl_ext_exit,
    input  logic              ctl_win_exit,
    input  logic              ctl_prio_shadow,
    input  logic [PRIO_W-1:0] prio_thresh,
    input  logic              prio_wr_en,
    input  logic [PRIO_W-1:0] prio_wr_data,
    output logic [PRIO_W-1:0] prio_rd_data,
    output logic              dlv_strobe,
    output logic              dlv_nmi,
    output logic              exit_strobe,
    output logic [REASON_W-1:0] exit_reason
);
    logic [NSRC-1:0]   req_v;
    logic [NSRC-1:0]   serve_v;
    logic [NSRC-1:0]   pend_v;
    logic              prio_hit;
    logic              nmi_taken;
    logic              ss_blk;
    logic              nmi_blk;
    logic [PRIO_W-1:0] shadow_q;

    gintv_prio_shadow #(.PRIO_W(PRIO_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prio_wr_en),
        .wr_data    (prio_wr_data),
        .ctl_shadow (ctl_prio_shadow),
        .long_mode  (long_mode),
        .thresh     (prio_thresh),
        .shadow_q   (shadow_q),
        .rd_data    (prio_rd_data),
        .below_hit  (prio_hit)
    );

    always_comb begin
        req_v           = '0;
        req_v[SRC_NMI]  = nmi_req;
        req_v[SRC_EXT]  = ext_req;
        req_v[SRC_PRIO] = prio_hit;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        gintv_pend u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_v[g]),
            .serve   (serve_v[g]),
            .pending (pend_v[g])
        );
    end

    gintv_intstate u_intstate (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_retire (insn_retire),
        .ss_load     (ss_load),
        .nmi_taken   (nmi_taken),
        .iret_done   (iret_done),
        .ss_blk      (ss_blk),
        .nmi_blk     (nmi_blk)
    );

    gintv_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend         (pend_v),
        .nmi_blk      (nmi_blk),
        .ss_blk       (ss_blk),
        .guest_if     (guest_if),
        .ctl_ext_exit (ctl_ext_exit),
        .ctl_win_exit (ctl_win_exit),
        .vm_resume    (vm_resume),
        .serve        (serve_v),
        .nmi_taken    (nmi_taken),
        .dlv_strobe   (dlv_strobe),
        .dlv_nmi      (dlv_nmi),
        .exit_strobe  (exit_strobe),
        .exit_reason  (exit_reason)
    );
endmodule

// File: rtl/gintv_checker.sv
module gintv_checker
    import gintv_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iret_done,
    input logic              guest_if,
    input logic              long_mode,
    input logic              ctl_ext_exit,
    input logic              ctl_prio_shadow,
    input logic              prio_wr_en,
    input logic [PRIO_W-1:0] shadow_q,
    input logic              dlv_strobe,
    input logic              dlv_nmi,
    input logic              exit_strobe,
    input logic [REASON_W-1:0] exit_reason
);
    logic blk_c;

    // independent model of NMI masking, driven from the output strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_c <= 1'b0;
        else if (dlv_strobe && dlv_nmi)
            blk_c <= !iret_done;
        else if (iret_done)
            blk_c <= 1'b0;
    end

    p_nmi_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_strobe && dlv_nmi) |-> !$past(blk_c));

    p_ext_never_dlv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_strobe && !dlv_nmi) |-> !$past(ctl_ext_exit));

    p_ext_needs_if_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_strobe && !dlv_nmi) |-> $past(guest_if));

    p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_wr_en && !(ctl_prio_shadow && long_mode)) |=> $stable(shadow_q));

    p_reason_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_strobe |-> (exit_reason != RSN_NONE));

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exit_strobe |=> (!exit_strobe && !dlv_strobe));

    p_single_dlv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_strobe |=> !dlv_strobe);
endmodule

bind gintv_ctrl gintv_checker #(.PRIO_W(PRIO_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .iret_done       (iret_done),
    .guest_if        (guest_if),
    .long_mode       (long_mode),
    .ctl_ext_exit    (ctl_ext_exit),
    .ctl_prio_shadow (ctl_prio_shadow),
    .prio_wr_en      (prio_wr_en),
    .shadow_q        (shadow_q),
    .dlv_strobe      (dlv_strobe),
    .dlv_nmi         (dlv_nmi),
    .exit_strobe     (exit_strobe),
    .exit_reason     (exit_reason)
);

// File: tb/gintv_ctrl_bench.sv
`timescale 1ns/1ps
module gintv_ctrl_bench;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 0, nmi_req = 0, iret_done = 0, insn_retire = 0, ss_load = 0;
    logic guest_if = 0, long_mode = 0, vm_resume = 0;
    logic ctl_ext_exit = 0, ctl_win_exit = 0, ctl_prio_shadow = 0;
    logic [PW-1:0] prio_thresh = '0;
    logic prio_wr_en = 0;
    logic [PW-1:0] prio_wr_data = '0;
    logic [PW-1:0] prio_rd_data;
    logic dlv_strobe, dlv_nmi, exit_strobe;
    logic [1:0] exit_reason;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gintv_ctrl #(.PRIO_W(PW)) u_gintv_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .nmi_req(nmi_req),
        .iret_done(iret_done), .insn_retire(insn_retire), .ss_load(ss_load),
        .guest_if(guest_if), .long_mode(long_mode), .vm_resume(vm_resume),
        .ctl_ext_exit(ctl_ext_exit), .ctl_win_exit(ctl_win_exit),
        .ctl_prio_shadow(ctl_prio_shadow), .prio_thresh(prio_thresh),
        .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data),
        .prio_rd_data(prio_rd_data), .dlv_strobe(dlv_strobe), .dlv_nmi(dlv_nmi),
        .exit_strobe(exit_strobe), .exit_reason(exit_reason)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // dlv_strobe, dlv_nmi, exit_strobe, exit_reason packed as one code
    function automatic int outs();
        return {dlv_strobe, dlv_nmi, exit_strobe, exit_reason};
    endfunction

    localparam int NONE  = 0;
    localparam int D_NMI = 5'b11000;
    localparam int D_EXT = 5'b10000;
    localparam int X_EXT = 5'b00101;
    localparam int X_WIN = 5'b00110;
    localparam int X_PRI = 5'b00111;

    task automatic resume();
        vm_resume = 1; step(); vm_resume = 0;
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", outs(), NONE);
        ctl_prio_shadow = 1; long_mode = 1; #1;
        chk("R1 shadow after reset", prio_rd_data, 0);
        ctl_prio_shadow = 0; long_mode = 0;
    endtask

    task automatic t_nmi();
        guest_if = 0;
        nmi_req = 1; step(); nmi_req = 0;
        chk("R2 nmi delivered with if=0", outs(), D_NMI);
        step();
        chk("R12 delivery lasts one cycle", outs(), NONE);
        nmi_req = 1; step(); nmi_req = 0;
        chk("R3 second nmi masked", outs(), NONE);
        step();
        chk("R3 second nmi still masked", outs(), NONE);
        iret_done = 1; step(); iret_done = 0;
        chk("R3 iret edge no delivery yet", outs(), NONE);
        step();
        chk("R3 held nmi delivered after iret", outs(), D_NMI);
        iret_done = 1; step(); iret_done = 0;
    endtask

    task automatic t_ext_dlv();
        ctl_ext_exit = 0; guest_if = 0;
        ext_req = 1; step(); ext_req = 0;
        chk("R5 ext held while if=0", outs(), NONE);
        step();
        chk("R5 ext still held", outs(), NONE);
        guest_if = 1; step();
        chk("R5 ext delivered when if=1", outs(), D_EXT);
        step();
        chk("R12 ext consumed", outs(), NONE);
    endtask

    task automatic t_ss();
        guest_if = 1;
        insn_retire = 1; ss_load = 1; step(); insn_retire = 0; ss_load = 0;
        ext_req = 1; step(); ext_req = 0;
        chk("R6 ext blocked after ss load", outs(), NONE);
        insn_retire = 1; step(); insn_retire = 0;
        chk("R6 block still seen at clearing boundary", outs(), NONE);
        step();
        chk("R6 ext delivered after block lifts", outs(), D_EXT);
        step();
    endtask

    task automatic t_ext_exit();
        ctl_ext_exit = 1; guest_if = 0;
        insn_retire = 1; ss_load = 1; step(); insn_retire = 0; ss_load = 0;
        ext_req = 1; step(); ext_req = 0;
        chk("R4 ext exits despite if=0 and ss block", outs(), X_EXT);
        step();
        chk("R11 halted after exit", outs(), NONE);
        nmi_req = 1; step(); nmi_req = 0;
        chk("R11 nmi not delivered while halted", outs(), NONE);
        step();
        chk("R11 still halted", outs(), NONE);
        resume();
        chk("R11 resume edge quiet", outs(), NONE);
        step();
        chk("R11 pending nmi served after resume", outs(), D_NMI);
        iret_done = 1; insn_retire = 1; step(); iret_done = 0; insn_retire = 0;
        ctl_ext_exit = 0;
        step();
    endtask

    task automatic t_window();
        guest_if = 0; ctl_win_exit = 1;
        step();
        chk("R7 no window exit with if=0", outs(), NONE);
        insn_retire = 1; ss_load = 1; step(); insn_retire = 0; ss_load = 0;
        guest_if = 1; step();
        chk("R7 window held by ss block", outs(), NONE);
        insn_retire = 1; step(); insn_retire = 0;
        chk("R6 window held at clearing boundary", outs(), NONE);
        step();
        chk("R7 window exit", outs(), X_WIN);
        ctl_win_exit = 0;
        step();
        resume();
        step();
        chk("R7 quiet after window control cleared", outs(), NONE);
    endtask

    task automatic t_prio();
        ctl_prio_shadow = 1; long_mode = 1; prio_thresh = 4'd5;
        prio_wr_en = 1; prio_wr_data = 4'd7; step(); prio_wr_en = 0;
        chk("R9 above threshold no exit", outs(), NONE);
        chk("R8 shadow reads 7", prio_rd_data, 7);
        prio_wr_en = 1; prio_wr_data = 4'd5; step(); prio_wr_en = 0;
        chk("R9 equal threshold no exit", outs(), NONE);
        prio_wr_en = 1; prio_wr_data = 4'd3; step(); prio_wr_en = 0;
        chk("R9 below threshold exit", outs(), X_PRI);
        chk("R8 shadow reads 3", prio_rd_data, 3);
        step();
        resume();
        long_mode = 0;
        prio_wr_en = 1; prio_wr_data = 4'd1; step(); prio_wr_en = 0;
        chk("R8 write outside 64-bit mode no exit", outs(), NONE);
        chk("R8 read gated outside 64-bit mode", prio_rd_data, 0);
        long_mode = 1; #1;
        chk("R8 write outside 64-bit mode ignored", prio_rd_data, 3);
        @(negedge clk);
        ctl_prio_shadow = 0;
        prio_wr_en = 1; prio_wr_data = 4'd2; step(); prio_wr_en = 0;
        chk("R8 write with shadow off no exit", outs(), NONE);
        ctl_prio_shadow = 1; #1;
        chk("R8 write with shadow off ignored", prio_rd_data, 3);
        @(negedge clk);
    endtask

    task automatic t_order();
        ctl_ext_exit = 1; ctl_win_exit = 1; guest_if = 1;
        ctl_prio_shadow = 1; long_mode = 1; prio_thresh = 4'd5;
        nmi_req = 1; ext_req = 1; prio_wr_en = 1; prio_wr_data = 4'd2;
        step();
        nmi_req = 0; ext_req = 0; prio_wr_en = 0;
        chk("R10 nmi first", outs(), D_NMI);
        step();
        chk("R10 gap after delivery", outs(), NONE);
        step();
        chk("R10 ext exit second", outs(), X_EXT);
        step();
        resume();
        step();
        chk("R10 priority exit third", outs(), X_PRI);
        step();
        resume();
        step();
        chk("R10 window exit fourth", outs(), X_WIN);
        ctl_win_exit = 0; ctl_ext_exit = 0;
        step();
        resume();
        step();
        chk("R10 nothing left", outs(), NONE);
        iret_done = 1; step(); iret_done = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_ext_dlv();
        t_ss();
        t_ext_exit();
        t_window();
        t_prio();
        t_order();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule